// File: doc/BRIEF.md
# Per-Channel Gamma Lookup

This block applies gamma correction to a stream of 24-bit RGB pixels. Each pixel carries a channel tag. One shared table memory holds a separate red, green and blue curve for every channel. Configuration logic loads the table through a pointer register and a data port, one entry per write. The pointer can optionally step forward by one after each data write, so a whole channel's curves can be streamed in without rewriting the pointer.

Each channel has its own gamma enable. While a channel's enable is set, its pixels leave with every 8-bit component replaced by that channel's table entry for the component. While it is clear, its pixels pass through untouched. The table storage is split into three banks, one per colour component, so all three components of a pixel are looked up in the same cycle.

If every channel's enable is clear at once, the table is treated as powered down and its contents are discarded. A pixel path with valid/ready handshaking and one register stage carries the results out.

Top module: `gamma_lut_ch`

## Requirements
- R1: The entry for channel c, component k (red 0, green 1, blue 2) and input code i sits at linear table address c*768 + k*256 + i. On the pixel bus, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R2: Writing the pointer with the step option set makes each later data write store at the current address and then advance the address by one.
- R3: Writing the pointer with the step option clear makes every later data write go to the same address, and the last value written stays.
- R4: When the pointer steps forward from the last address, 2303, it moves to 0.
- R5: If a pixel is accepted while its channel's enable is set, each of its components is replaced by the matching table entry. The result appears on the output in the cycle after acceptance. The enable is sampled when the pixel is accepted.
- R6: If a pixel is accepted while its channel's enable is clear, it leaves unchanged.
- R7: In any cycle where all enables are clear, data writes are dropped and every entry is marked lost. A lost entry reads as zero until it is written again.
- R8: in_ready is high exactly when the output stage is empty or out_ready is high. While out_valid is high and out_ready is low, out_pix and out_chan hold their values. An accepted pixel's tag appears on out_chan.
- R9: After reset, out_valid is low, the pointer is 0, the step option is off, and all entries are lost.
- R10: A pixel whose tag is 3 or above names no channel and leaves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gamma_en | input | 3 | Per-channel gamma enable, bit c for channel c |
| lut_addr_we | input | 1 | Load the table pointer |
| lut_addr_val | input | 12 | New pointer value |
| lut_addr_inc | input | 1 | Step option stored with the pointer |
| lut_data_we | input | 1 | Write one table entry at the pointer |
| lut_data_val | input | 8 | Entry value |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_chan | input | 2 | Input channel tag |
| in_pix | input | 24 | Input pixel, red in bits 23:16 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_chan | output | 2 | Output channel tag |
| out_pix | output | 24 | Output pixel |

## Verification
The bench loads every channel's curves with distinct values. Each channel, each component and each bit position is then checked, so an address map that swaps components, orders channels wrongly or slices the pixel in the wrong place shows up as wrong codes. The pointer is driven across the last address, and a design that failed to wrap would corrupt an entry beyond the map instead of entry 0. A power-down followed by writes is used to catch two faults: a design that keeps stale entries returns old curve values instead of zero, and a design that accepts writes while powered down returns the dropped value. A stalled output with a second pixel waiting exposes a stage that overwrites or loses data under backpressure.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

   // Number of colour components per pixel; bank k serves component k.
   localparam int NUM_COMP = 3;

   typedef enum logic [1:0] {
      COMP_RED   = 2'd0,
      COMP_GREEN = 2'd1,
      COMP_BLUE  = 2'd2
   } comp_e;

   // Channel tag width, kept at least one bit wide.
   function automatic int tag_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/gamma_lut_ptr.sv
module gamma_lut_ptr #(
   parameter  int NUM_CH  = 3,
   parameter  int COMP_W  = 8,
   localparam int ENTRIES = 1 << COMP_W,
   localparam int CH_SPAN = gamma_lut_pkg::NUM_COMP * ENTRIES,
   localparam int TOTAL   = NUM_CH * CH_SPAN,
   localparam int ADDR_W  = $clog2(TOTAL),
   localparam int CH_W    = gamma_lut_pkg::tag_width(NUM_CH),
   localparam int BANK_AW = CH_W + COMP_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                addr_we,
   input  logic [ADDR_W-1:0]   addr_val,
   input  logic                addr_inc,
   input  logic                data_we,
   output logic [gamma_lut_pkg::NUM_COMP-1:0] wr_sel,
   output logic [BANK_AW-1:0]  wr_addr
);

   logic [ADDR_W-1:0] ptr_q;
   logic              inc_q;
   logic [31:0]       p_ext;
   logic [31:0]       chn;
   logic [31:0]       rem;
   logic [31:0]       cmp;
   logic [31:0]       idx;
   logic              in_range;
   logic              at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         inc_q <= 1'b0;
      end else if (addr_we) begin
         ptr_q <= addr_val;
         inc_q <= addr_inc;
      end else if (data_we && inc_q) begin
         ptr_q <= at_last ? '0 : ptr_q + 1'b1;
      end
   end

   always_comb begin
      p_ext    = 32'(ptr_q);
      at_last  = (p_ext >= 32'(TOTAL - 1));
      in_range = (p_ext < 32'(TOTAL));
      chn      = p_ext / 32'(CH_SPAN);
      rem      = p_ext % 32'(CH_SPAN);
      cmp      = rem / 32'(ENTRIES);
      idx      = rem % 32'(ENTRIES);
      wr_addr  = {chn[CH_W-1:0], idx[COMP_W-1:0]};
   end

   for (genvar k = 0; k < gamma_lut_pkg::NUM_COMP; k++) begin : g_sel
      assign wr_sel[k] = data_we && in_range && (cmp == 32'(k));
   end

endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
   parameter int DEPTH = 768,
   parameter int AW    = 10,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_on,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

   logic [DW-1:0]    mem [DEPTH];
   logic [DEPTH-1:0] vld;
   logic             rd_hit;

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("gamma_lut_bank: DEPTH does not fit the address width");
   end

   always_ff @(posedge clk) begin
      if (we && pwr_on) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !pwr_on) begin
         vld <= '0;
      end else if (we) begin
         vld[waddr] <= 1'b1;
      end
   end

   assign rd_hit = ({1'b0, raddr} < DEPTH_V) && vld[raddr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= rd_hit ? mem[raddr] : '0;
      end
   end

endmodule

// File: rtl/gamma_lut_ch.sv
module gamma_lut_ch #(
   parameter  int NUM_CH  = 3,
   parameter  int COMP_W  = 8,
   localparam int NCOMP   = gamma_lut_pkg::NUM_COMP,
   localparam int ENTRIES = 1 << COMP_W,
   localparam int TOTAL   = NUM_CH * NCOMP * ENTRIES,
   localparam int ADDR_W  = $clog2(TOTAL),
   localparam int CH_W    = gamma_lut_pkg::tag_width(NUM_CH),
   localparam int PIX_W   = NCOMP * COMP_W,
   localparam int BANK_AW = CH_W + COMP_W,
   localparam int BANK_D  = NUM_CH * ENTRIES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] gamma_en,
   input  logic              lut_addr_we,
   input  logic [ADDR_W-1:0] lut_addr_val,
   input  logic              lut_addr_inc,
   input  logic              lut_data_we,
   input  logic [COMP_W-1:0] lut_data_val,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [PIX_W-1:0]  in_pix,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CH_W-1:0]   out_chan,
   output logic [PIX_W-1:0]  out_pix
);

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("gamma_lut_ch: NUM_CH must lie in 1..16");
   end
   if (COMP_W < 2 || COMP_W > 10) begin : g_bad_w
      $error("gamma_lut_ch: COMP_W must lie in 2..10");
   end
   if (ADDR_W > 30) begin : g_bad_aw
      $error("gamma_lut_ch: table too large");
   end

   logic               pwr_on;
   logic               accept;
   logic               sel_en;
   logic               use_lut;
   logic [NCOMP-1:0]   wr_sel;
   logic [BANK_AW-1:0] wr_addr;
   logic [COMP_W-1:0]  rd_data [NCOMP];

   logic               vld_q;
   logic [CH_W-1:0]    chan_q;
   logic [PIX_W-1:0]   pix_q;
   logic               lut_q;

   assign pwr_on   = |gamma_en;
   assign in_ready = !vld_q || out_ready;
   assign accept   = in_valid && in_ready;

   // Enable of the tagged channel; a tag naming no channel selects none.
   always_comb begin
      sel_en = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (32'(in_chan) == 32'(c)) begin
            sel_en = gamma_en[c];
         end
      end
   end
   assign use_lut = sel_en;

   gamma_lut_ptr #(
      .NUM_CH (NUM_CH),
      .COMP_W (COMP_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_we  (lut_addr_we),
      .addr_val (lut_addr_val),
      .addr_inc (lut_addr_inc),
      .data_we  (lut_data_we),
      .wr_sel   (wr_sel),
      .wr_addr  (wr_addr)
   );

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      localparam int LSB = (NCOMP - 1 - k) * COMP_W;

      gamma_lut_bank #(
         .DEPTH (BANK_D),
         .AW    (BANK_AW),
         .DW    (COMP_W)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .pwr_on (pwr_on),
         .we     (wr_sel[k]),
         .waddr  (wr_addr),
         .wdata  (lut_data_val),
         .re     (accept && use_lut),
         .raddr  ({in_chan, in_pix[LSB +: COMP_W]}),
         .rdata  (rd_data[k])
      );

      assign out_pix[LSB +: COMP_W] = lut_q ? rd_data[k] : pix_q[LSB +: COMP_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         chan_q <= '0;
         pix_q  <= '0;
         lut_q  <= 1'b0;
      end else if (accept) begin
         vld_q  <= 1'b1;
         chan_q <= in_chan;
         pix_q  <= in_pix;
         lut_q  <= use_lut;
      end else if (out_ready) begin
         vld_q  <= 1'b0;
      end
   end

   assign out_valid = vld_q;
   assign out_chan  = chan_q;

endmodule

// File: rtl/gamma_lut_ch_chk.sv
module gamma_lut_ch_chk #(
   parameter  int NUM_CH = 3,
   parameter  int COMP_W = 8,
   localparam int CH_W   = gamma_lut_pkg::tag_width(NUM_CH),
   localparam int PIX_W  = gamma_lut_pkg::NUM_COMP * COMP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] gamma_en,
   input logic              in_valid,
   input logic              in_ready,
   input logic [CH_W-1:0]   in_chan,
   input logic [PIX_W-1:0]  in_pix,
   input logic              out_valid,
   input logic              out_ready,
   input logic [CH_W-1:0]   out_chan,
   input logic [PIX_W-1:0]  out_pix
);

   logic chk_en;

   always_comb begin
      chk_en = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (32'(in_chan) == 32'(c)) chk_en = gamma_en[c];
      end
   end

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_chan));

   assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   assert_accept_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && out_chan == $past(in_chan));

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && !in_valid |=> !out_valid);

   assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !chk_en |=> out_pix == $past(in_pix));

   assert_bad_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && (32'(in_chan) >= 32'(NUM_CH)) |=> out_pix == $past(in_pix));

endmodule

bind gamma_lut_ch gamma_lut_ch_chk #(
   .NUM_CH (NUM_CH),
   .COMP_W (COMP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gamma_en  (gamma_en),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_chan   (in_chan),
   .in_pix    (in_pix),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_chan  (out_chan),
   .out_pix   (out_pix)
);

// File: tb/gamma_lut_ch_bench.sv
`timescale 1ns/1ps
module gamma_lut_ch_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  gamma_en = 3'b000;
   logic        lut_addr_we = 1'b0;
   logic [11:0] lut_addr_val = '0;
   logic        lut_addr_inc = 1'b0;
   logic        lut_data_we = 1'b0;
   logic [7:0]  lut_data_val = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_chan = '0;
   logic [23:0] in_pix = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [1:0]  out_chan;
   logic [23:0] out_pix;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   gamma_lut_ch u_gamma_lut_ch (
      .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en),
      .lut_addr_we(lut_addr_we), .lut_addr_val(lut_addr_val), .lut_addr_inc(lut_addr_inc),
      .lut_data_we(lut_data_we), .lut_data_val(lut_data_val),
      .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_pix(in_pix),
      .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_pix(out_pix)
   );

   // Stimulus vectors: {tag, enable mask, pixel}; no mask is all-clear.
   localparam logic [28:0] VEC [10] = '{
      {2'd0, 3'b111, 24'h000102},
      {2'd1, 3'b111, 24'hFF807F},
      {2'd2, 3'b111, 24'h123456},
      {2'd0, 3'b110, 24'hABCDEF},
      {2'd1, 3'b110, 24'h01FE10},
      {2'd2, 3'b011, 24'h998877},
      {2'd3, 3'b111, 24'hDEAD01},
      {2'd1, 3'b101, 24'h556677},
      {2'd2, 3'b100, 24'h00FF80},
      {2'd0, 3'b001, 24'hFFFFFF}
   };

   function automatic logic [7:0] tbl(input int c, input int k, input int i);
      return 8'(((i * 7) ^ (c * 64 + k * 21 + 3)) & 255);
   endfunction

   function automatic logic [23:0] model(input logic [1:0] ch, input logic [2:0] en,
                                         input logic [23:0] px);
      if (ch < 2'd3) begin
         if (en[ch]) begin
            return {tbl(int'(ch), 0, int'(px[23:16])),
                    tbl(int'(ch), 1, int'(px[15:8])),
                    tbl(int'(ch), 2, int'(px[7:0]))};
         end
      end
      return px;
   endfunction

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_ptr(input logic [11:0] a, input logic inc);
      @(negedge clk);
      lut_addr_we = 1'b1; lut_addr_val = a; lut_addr_inc = inc;
      @(negedge clk);
      lut_addr_we = 1'b0;
   endtask

   task automatic put(input logic [7:0] d);
      @(negedge clk);
      lut_data_we = 1'b1; lut_data_val = d;
      @(negedge clk);
      lut_data_we = 1'b0;
   endtask

   // Sends one pixel with out_ready high; returns {valid, tag, pixel}.
   task automatic send(input logic [1:0] ch, input logic [2:0] en, input logic [23:0] px,
                       output logic [31:0] got);
      @(negedge clk);
      gamma_en = en; in_chan = ch; in_pix = px; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      got = {5'd0, out_valid, out_chan, out_pix};
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      logic [31:0] got;
      logic [23:0] held;

      // R9: reset state
      gamma_en = 3'b001;
      repeat (3) @(negedge clk);
      check("R9 out_valid low in reset", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle ready after reset", {30'd0, in_ready, out_valid}, 32'd2);

      // R3 and R9: pointer at 0 with step off; two writes land on entry 0
      put(8'hAA);
      put(8'hC3);
      send(2'd0, 3'b001, 24'h000000, got);
      check("R3 R9 repeat write at 0, unwritten entries zero", got, {5'd0, 1'b1, 2'd0, 24'hC30000});

      // R1 R2: full load with stepping pointer
      set_ptr(12'd0, 1'b1);
      for (int a = 0; a < 2304; a++) begin
         @(negedge clk);
         lut_data_we  = 1'b1;
         lut_data_val = tbl(a / 768, (a % 768) / 256, a % 256);
      end
      @(negedge clk);
      lut_data_we = 1'b0;

      // R1 R2 R5 R6 R10: vector table
      for (int v = 0; v < 10; v++) begin
         send(VEC[v][28:27], VEC[v][26:24], VEC[v][23:0], got);
         check("R1 R2 R5 R6 R10 vector", got,
               {5'd0, 1'b1, VEC[v][28:27], model(VEC[v][28:27], VEC[v][26:24], VEC[v][23:0])});
      end

      // R4: wrap from the last address to 0
      set_ptr(12'd2303, 1'b1);
      put(8'h11);
      put(8'h22);
      send(2'd2, 3'b101, 24'h0000FF, got);
      check("R4 last entry written", got, {5'd0, 1'b1, 2'd2, tbl(2, 0, 0), tbl(2, 1, 0), 8'h11});
      send(2'd0, 3'b101, 24'h000000, got);
      check("R4 wrapped write to entry 0", got, {5'd0, 1'b1, 2'd0, 8'h22, tbl(0, 1, 0), tbl(0, 2, 0)});

      // R7: power-down loses contents and drops writes
      @(negedge clk);
      gamma_en = 3'b000;
      repeat (2) @(negedge clk);
      set_ptr(12'd777, 1'b0);
      put(8'h77);
      @(negedge clk);
      gamma_en = 3'b010;
      send(2'd1, 3'b010, 24'h090000, got);
      check("R7 write while off dropped", got, {5'd0, 1'b1, 2'd1, 24'h000000});
      send(2'd1, 3'b010, 24'h050607, got);
      check("R7 entries lost after power-down", got, {5'd0, 1'b1, 2'd1, 24'h000000});
      set_ptr(12'd771, 1'b1);
      put(8'h5E);
      put(8'h6F);
      send(2'd1, 3'b010, 24'h030000, got);
      check("R7 R2 rewritten entry", got, {5'd0, 1'b1, 2'd1, 24'h5E0000});
      send(2'd1, 3'b010, 24'h040000, got);
      check("R2 stepped entry", got, {5'd0, 1'b1, 2'd1, 24'h6F0000});

      // R8: backpressure, with bypass pixels
      @(negedge clk);
      gamma_en = 3'b000; out_ready = 1'b0;
      in_chan = 2'd2; in_pix = 24'h13579B; in_valid = 1'b1;
      @(negedge clk);
      in_chan = 2'd1; in_pix = 24'h2468AC;
      check("R8 stalled output and blocked input", {5'd0, out_valid, in_ready, out_pix},
            {5'd0, 1'b1, 1'b0, 24'h13579B});
      held = out_pix;
      repeat (3) @(negedge clk);
      check("R8 output held under stall", {6'd0, out_chan, out_pix}, {6'd0, 2'd2, held});
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 waiting pixel taken after release", {5'd0, out_valid, out_chan, out_pix},
            {5'd0, 1'b1, 2'd1, 24'h2468AC});
      @(negedge clk);
      check("R8 stage empties", {31'd0, out_valid}, 32'd0);

      report();
   end

endmodule